// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. Software writes a rounding-mode field, a flush-to-zero enable and five trap enables. The block keeps five sticky exception flags, a current compare condition bit and an eleven-position compare history. It drives the rounding mode and the flush-to-zero control to the arithmetic datapath, which is a separate block.

Each arithmetic result may come with a raw 5-bit exception vector. The block ORs that vector into the sticky flags. In the next cycle it raises a one-cycle trap request if any newly reported exception has its enable set. A compare result arrives as a 2-bit relation code with a condition-select field, a target index and the compare's own exception vector. The exceptions are merged first. The selected condition bit then goes either to one addressed history bit or to the current condition bit, and in the second case the history shifts by one place.

Top module: `fpsr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, status_o is 0 and trap_o is 0.
- R2: When wr_en_i is high, the whole register takes wr_data_i on the next edge. Any exception or compare input in the same cycle is dropped, and trap_o is 0 in the following cycle.
- R3: round_mode_o equals status bits 10:9 (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity), and flush_o equals status bit 5.
- R4: Exception vectors use bit 0 for inexact, bit 1 for underflow, bit 2 for overflow, bit 3 for divide-by-zero and bit 4 for invalid. A vector is ORed into status bits 31:27. Those flags are cleared only by a write.
- R5: trap_o pulses high for exactly the cycle after an update in which the incoming exception vector ANDed with the enables in status bits 4:0 is nonzero. Flags that were already set before that update do not raise it.
- R6: An exception report with an all-zero vector, or a cycle with no input activity, leaves the register unchanged and keeps trap_o low.
- R7: The compare result is bit 4 of cmp_cond_i for relation 0 (greater), bit 3 for relation 1 (less), bit 2 for relation 2 (equal) and bit 1 for relation 3 (unordered). Bit 0 (the signaling-compare select) has no effect on the stored result.
- R8: A compare with index y from 1 to 11 writes its result to status bit 22-y and leaves every other condition bit unchanged.
- R9: A compare with index 0 moves bits 21:12 into bits 20:11 and moves old bit 26 into bit 21. It then writes the new result into bit 26.
- R10: A compare with an index of 12 or more changes no condition bit.
- R11: A compare's own exception vector is merged, and checked for traps, exactly as in R4 and R5. When an arithmetic report comes in the same cycle, the two vectors are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Software load of the whole register |
| wr_data_i | input | 32 | Value to load |
| exc_valid_i | input | 1 | Arithmetic exception report present |
| exc_flags_i | input | 5 | Raw exception vector of the arithmetic operation |
| cmp_valid_i | input | 1 | Compare result present |
| cmp_rel_i | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_cond_i | input | 5 | Condition-select field of the compare |
| cmp_idx_i | input | 4 | Target index; 0 selects the queued form |
| cmp_exc_i | input | 5 | Exception vector raised by the compare |
| status_o | output | 32 | Current register value |
| round_mode_o | output | 2 | Rounding mode to the arithmetic unit |
| flush_o | output | 1 | Flush-to-zero enable to the arithmetic unit |
| trap_o | output | 1 | One-cycle trap request |

## Verification
Any wrong internal state is visible on status_o one cycle after the update that caused it, because the whole register appears there. A bad queue shift shows up in bits 26 and 21:11. A bad flag merge shows up in bits 31:27. A bad trap decision shows up on trap_o one edge after the exception report. The bench predicts every field after every stimulus cycle, so a fault is caught in the first cycle in which it changes the register.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int CSR_W    = 32;
  localparam int EXC_W    = 5;
  localparam int FLAG_LSB = 27;
  localparam int ENA_LSB  = 0;
  localparam int RM_LSB   = 9;
  localparam int RM_W     = 2;
  localparam int FTZ_BIT  = 5;
  localparam int CBIT     = 26;
  localparam int Q_TOP    = 21;
  localparam int Q_BOT    = 11;
  localparam int Q_DEPTH  = Q_TOP - Q_BOT + 1;
  localparam int IDX_W    = 4;
  localparam int COND_W   = 5;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;
endpackage

// File: rtl/fpsr_exc_merge.sv
module fpsr_exc_merge
  import fpsr_pkg::*;
(
  input  logic [CSR_W-1:0] cur_i,
  input  logic [EXC_W-1:0] flags_i,
  output logic [CSR_W-1:0] nxt_o,
  output logic             trap_req_o
);
  always_comb begin
    nxt_o = cur_i;
    nxt_o[FLAG_LSB +: EXC_W] = cur_i[FLAG_LSB +: EXC_W] | flags_i;
    // only freshly reported exceptions can trap
    trap_req_o = |(flags_i & cur_i[ENA_LSB +: EXC_W]);
  end
endmodule

// File: rtl/fpsr_cmp_update.sv
module fpsr_cmp_update
  import fpsr_pkg::*;
(
  input  logic [CSR_W-1:0]  cur_i,
  input  logic              valid_i,
  input  rel_e              rel_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CSR_W-1:0]  nxt_o
);
  logic sel;

  always_comb begin
    unique case (rel_i)
      REL_GT:  sel = cond_i[4];
      REL_LT:  sel = cond_i[3];
      REL_EQ:  sel = cond_i[2];
      default: sel = cond_i[1];
    endcase
  end

  always_comb begin
    nxt_o = cur_i;
    if (valid_i) begin
      if (idx_i == '0) begin
        nxt_o[Q_TOP-1:Q_BOT] = cur_i[Q_TOP:Q_BOT+1];
        nxt_o[Q_TOP]         = cur_i[CBIT];
        nxt_o[CBIT]          = sel;
      end else begin
        for (int k = 1; k <= Q_DEPTH; k++) begin
          if (idx_i == IDX_W'(k)) nxt_o[Q_TOP+1-k] = sel;
        end
      end
    end
  end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wr_data_i,
  input  logic              exc_valid_i,
  input  logic [EXC_W-1:0]  exc_flags_i,
  input  logic              cmp_valid_i,
  input  logic [1:0]        cmp_rel_i,
  input  logic [COND_W-1:0] cmp_cond_i,
  input  logic [IDX_W-1:0]  cmp_idx_i,
  input  logic [EXC_W-1:0]  cmp_exc_i,
  output logic [CSR_W-1:0]  status_o,
  output logic [RM_W-1:0]   round_mode_o,
  output logic              flush_o,
  output logic              trap_o
);
  logic [CSR_W-1:0] csr_q, merged, updated;
  logic [EXC_W-1:0] flags;
  logic             trap_req;

  assign flags = (exc_valid_i ? exc_flags_i : '0) | (cmp_valid_i ? cmp_exc_i : '0);

  fpsr_exc_merge u_merge (
    .cur_i      (csr_q),
    .flags_i    (flags),
    .nxt_o      (merged),
    .trap_req_o (trap_req)
  );

  // condition update sees the register after the exception merge
  fpsr_cmp_update u_cmp (
    .cur_i   (merged),
    .valid_i (cmp_valid_i),
    .rel_i   (rel_e'(cmp_rel_i)),
    .cond_i  (cmp_cond_i),
    .idx_i   (cmp_idx_i),
    .nxt_o   (updated)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      trap_o <= 1'b0;
    end else if (wr_en_i) begin
      csr_q  <= wr_data_i;
      trap_o <= 1'b0;
    end else begin
      csr_q  <= updated;
      trap_o <= trap_req;
    end
  end

  assign status_o     = csr_q;
  assign round_mode_o = csr_q[RM_LSB +: RM_W];
  assign flush_o      = csr_q[FTZ_BIT];
endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk
  import fpsr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CSR_W-1:0] wr_data_i,
  input logic             exc_valid_i,
  input logic             cmp_valid_i,
  input logic [CSR_W-1:0] status_o,
  input logic             trap_o
);
  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> status_o == $past(wr_data_i));

  // R2
  wr_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !trap_o);

  // R6
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !exc_valid_i && !cmp_valid_i) |=> ($stable(status_o) && !trap_o));

  // R4
  sticky_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((status_o[FLAG_LSB +: EXC_W] & $past(status_o[FLAG_LSB +: EXC_W]))
                  == $past(status_o[FLAG_LSB +: EXC_W])));

  // R5
  enable_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> status_o[ENA_LSB +: EXC_W] == $past(status_o[ENA_LSB +: EXC_W]));
endmodule

bind fpsr_ctrl fpsr_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .exc_valid_i (exc_valid_i),
  .cmp_valid_i (cmp_valid_i),
  .status_o    (status_o),
  .trap_o      (trap_o)
);

// File: tb/tb_fpsr_ctrl.sv
module tb_fpsr_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_flags = '0;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_rel = '0;
  logic [4:0]  cmp_cond = '0;
  logic [3:0]  cmp_idx = '0;
  logic [4:0]  cmp_exc = '0;
  logic [31:0] status;
  logic [1:0]  round_mode;
  logic        flush;
  logic        trap;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] st;
    logic        tr;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] m_st = '0;

  always #5 clk = ~clk;

  fpsr_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .exc_valid_i(exc_valid), .exc_flags_i(exc_flags), .cmp_valid_i(cmp_valid),
    .cmp_rel_i(cmp_rel), .cmp_cond_i(cmp_cond), .cmp_idx_i(cmp_idx),
    .cmp_exc_i(cmp_exc), .status_o(status), .round_mode_o(round_mode),
    .flush_o(flush), .trap_o(trap)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the result
  task automatic step(input bit w, input logic [31:0] wd, input bit ev, input logic [4:0] ef,
                      input bit cv, input logic [1:0] rel, input logic [4:0] cond,
                      input logic [3:0] idx, input logic [4:0] ce, input string tag);
    exp_t e;
    logic [4:0] f;
    logic c;
    @(negedge clk);
    wr_en = w; wr_data = wd; exc_valid = ev; exc_flags = ef;
    cmp_valid = cv; cmp_rel = rel; cmp_cond = cond; cmp_idx = idx; cmp_exc = ce;
    e.tag = tag;
    if (w) begin
      m_st = wd; e.tr = 1'b0;
    end else begin
      f = (ev ? ef : 5'd0) | (cv ? ce : 5'd0);
      e.tr = |(f & m_st[4:0]);
      m_st[31:27] = m_st[31:27] | f;
      if (cv) begin
        c = cond[4 - rel];
        if (idx == 0) begin
          m_st[20:11] = m_st[21:12];
          m_st[21] = m_st[26];
          m_st[26] = c;
        end else if (idx <= 11) begin
          m_st[22 - idx] = c;
        end
      end
    end
    e.st = m_st;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, '0, 0, '0, 0, '0, '0, '0, '0, tag);
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    step(1, d, 0, '0, 0, '0, '0, '0, '0, tag);
  endtask

  task automatic exc(input logic [4:0] f, input string tag);
    step(0, '0, 1, f, 0, '0, '0, '0, '0, tag);
  endtask

  task automatic cmp(input logic [1:0] rel, input logic [4:0] cond, input logic [3:0] idx,
                     input logic [4:0] ce, input string tag);
    step(0, '0, 0, '0, 1, rel, cond, idx, ce, tag);
  endtask

  // monitor: compares each predicted item after the edge that produced it
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(status === e.st, e.tag, status, e.st);
      check(trap === e.tr, {e.tag, " trap"}, {31'd0, trap}, {31'd0, e.tr});
      // R3 outputs follow the register fields
      check(round_mode === e.st[10:9], "R3 round_mode", {30'd0, round_mode}, {30'd0, e.st[10:9]});
      check(flush === e.st[5], "R3 flush", {31'd0, flush}, {31'd0, e.st[5]});
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #23;
    check(status === 32'd0, "R1 status in reset", status, 32'd0);
    check(trap === 1'b0, "R1 trap in reset", {31'd0, trap}, 32'd0);
    rst_ni = 1'b1;
    idle("R1 after reset");

    wr(32'h0000_0220, "R3 toward zero + ftz");
    wr(32'h0000_0400, "R3 toward +inf");
    wr(32'h0000_0600, "R3 toward -inf");
    wr(32'h0000_0000, "R3 nearest");

    wr(32'h0000_0004, "R2 load enables");
    exc(5'b00001, "R4 inexact sticky no trap");
    exc(5'b00100, "R5 overflow traps");
    idle("R5 trap is one pulse");
    exc(5'b00001, "R5 old overflow flag does not retrigger");
    exc(5'b00000, "R6 zero vector no change");
    idle("R6 idle");
    exc(5'b11010, "R4 mixed flags");
    step(1, 32'h0000_0013, 1, 5'b10011, 1, 2'd0, 5'b10000, 4'd0, 5'b10000,
         "R2 write wins over updates");
    idle("R2 no trap after write");
    exc(5'b10000, "R5 invalid enabled traps");

    wr(32'h0400_1000, "R9 preload queue");
    cmp(2'd1, 5'b01000, 4'd0, '0, "R9 queued shift less true");
    cmp(2'd0, 5'b01000, 4'd0, '0, "R9 queued shift greater false");
    cmp(2'd2, 5'b00100, 4'd0, '0, "R7 equal selects bit2");
    cmp(2'd3, 5'b00010, 4'd0, '0, "R7 unordered selects bit1");
    cmp(2'd3, 5'b11101, 4'd0, '0, "R7 bit0 ignored unordered false");
    cmp(2'd2, 5'b00101, 4'd0, '0, "R7 bit0 ignored equal true");

    wr(32'h0000_0000, "R8 clear");
    cmp(2'd0, 5'b10000, 4'd1, '0, "R8 idx1 bit21");
    cmp(2'd0, 5'b10000, 4'd11, '0, "R8 idx11 bit11");
    cmp(2'd1, 5'b01000, 4'd5, '0, "R8 idx5 bit17");
    cmp(2'd1, 5'b10111, 4'd1, '0, "R8 idx1 cleared");
    cmp(2'd0, 5'b10000, 4'd12, '0, "R10 idx12 ignored");
    cmp(2'd0, 5'b10000, 4'd15, '0, "R10 idx15 ignored");

    wr(32'h0000_0010, "R11 enable invalid");
    cmp(2'd3, 5'b00011, 4'd0, 5'b10000, "R11 signaling compare invalid traps");
    step(0, '0, 1, 5'b00001, 1, 2'd0, 5'b10000, 4'd2, 5'b00100, "R11 merged vectors");
    idle("R11 idle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule